// File: doc/BRIEF.md
# Dual-Slope Converter Phase and Flag Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs a measurement cycle with three phases and then repeats it without a break. A fixed-length auto-zero phase comes first. A fixed-length signal-integrate phase follows. The last phase is a deintegrate phase, which ends when the comparator reports a zero crossing or when the count passes full scale. During deintegrate the block counts clocks, and that count is the conversion result.

The block drives four status flags: busy, over-range, under-range and input polarity. Each flag is set and cleared at a different phase boundary. When the input is over range, busy stays high until the deintegrate count runs out. The analog integrator, the comparator and the reference switching sit outside the block. The block only samples a comparator zero-crossing bit and an input-sign bit.

Top module: `dsc_flag_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to auto-zero. `busy`, `over_range`, `under_range` and `polarity` go low, and `result` goes to 0.
- R2: Auto-zero lasts `AZ_LEN` clocks and signal-integrate lasts `INT_LEN` clocks. `busy` rises on the edge that ends auto-zero and stays high through signal-integrate and deintegrate.
- R3: During deintegrate, the first clock edge that samples `zero_cross` high ends the cycle. On that edge `busy` falls, and `result` takes the number of deintegrate clocks that came before that edge (0 to `FULL_SCALE`).
- R4: If the deintegrate phase has counted `FULL_SCALE`+1 clocks with no zero crossing, the cycle ends anyway. On that edge `busy` falls, `over_range` rises, and `result` takes `FULL_SCALE`+1.
- R5: `over_range` stays high through the next auto-zero and signal-integrate phases. It clears on the edge that starts the next deintegrate phase.
- R6: `under_range` rises at the fall of `busy` when the cycle ends on a zero crossing with `result` at or below `UR_LIMIT`. It clears on the next rise of `busy`. It is never high together with `over_range`.
- R7: `polarity` copies `in_positive` (1 = positive input) on the edge that starts deintegrate. It holds that value at every other edge, including cycles that end on zero or on over-range.
- R8: `zero_cross` is ignored during auto-zero and signal-integrate: the phase lengths and flags are the same as if it were low.
- R9: After the deintegrate phase ends, auto-zero starts again at once, and cycles repeat with no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zero_cross | input | 1 | Comparator reports integrator zero crossing |
| in_positive | input | 1 | Sign of the input being measured, 1 = positive |
| busy | output | 1 | High from start of integrate to end of measurement |
| over_range | output | 1 | Last measurement exceeded full scale |
| under_range | output | 1 | Last measurement at or below the low limit |
| polarity | output | 1 | Input sign captured at deintegrate start |
| result | output | $clog2(FULL_SCALE+2) | Deintegrate count of the last measurement |

## Verification
The bench aims at the edges of the deintegrate window. It uses a crossing on the very first deintegrate clock, which must give a result of 0 and raise under-range. It uses a crossing exactly at full scale, which must not be taken as over-range. It uses counts just above and just below the under-range limit. An off-by-one design would report over-range one clock early or late, or flag under-range at the limit plus one.

An over-range cycle is followed directly by a short cycle. This shows whether over-range clears at the start of the next deintegrate phase rather than at the next rise of busy. The bench also pulses zero-crossing during the integrate and auto-zero phases, and flips the sign input in the middle of deintegrate. A design that listens outside its window would cut a phase short or let polarity follow the input.

// File: rtl/dsc_pkg.sv
// Shared types for the dual-slope phase and flag sequencer.
// Assumes: three phases only; the encoding carries no external meaning.
package dsc_pkg;
    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;
endpackage

// File: rtl/dsc_phase_seq.sv
// Phase sequencer: walks auto-zero -> integrate -> deintegrate -> auto-zero.
// It keeps one shared clock counter and emits one-cycle boundary events.
// Assumes: AZ_LEN, INT_LEN >= 1, and CW wide enough for max(AZ_LEN, INT_LEN, FS+1).
module dsc_phase_seq
    import dsc_pkg::*;
#(
    parameter int AZ_LEN     = 10000,
    parameter int INT_LEN    = 10001,
    parameter int FULL_SCALE = 20000,
    parameter int CW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_cross,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          ev_int_start,
    output logic          ev_deint_start,
    output logic          ev_end_zc,
    output logic          ev_end_or
);
    localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_LEN - 1);
    localparam logic [CW-1:0] INT_LAST = CW'(INT_LEN - 1);
    localparam logic [CW-1:0] DE_LAST  = CW'(FULL_SCALE);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    // Decode the boundary events from the current phase, the count and the comparator.
    always_comb begin
        ev_int_start   = (phase_q == PH_AZ)    && (cnt_q == AZ_LAST);
        ev_deint_start = (phase_q == PH_INT)   && (cnt_q == INT_LAST);
        ev_end_zc      = (phase_q == PH_DEINT) && zero_cross;
        ev_end_or      = (phase_q == PH_DEINT) && !zero_cross && (cnt_q == DE_LAST);
    end

    // Advance the phase and the shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_AZ;
            cnt_q   <= '0;
        end else if (ev_int_start) begin
            phase_q <= PH_INT;
            cnt_q   <= '0;
        end else if (ev_deint_start) begin
            phase_q <= PH_DEINT;
            cnt_q   <= '0;
        end else if (ev_end_zc || ev_end_or) begin
            phase_q <= PH_AZ;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;
    assign cnt   = cnt_q;

    AST_DEINT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DEINT) |-> (cnt_q <= DE_LAST)); // R4
    AST_AZ_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_AZ) |=> (phase_q != PH_DEINT)); // R8
    AST_INT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_INT) |-> (cnt_q <= INT_LAST)); // R2
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd3)); // R9
endmodule

// File: rtl/dsc_flags.sv
// Flag and result register bank. Each flag has its own set and clear event.
// Assumes: the events come from dsc_phase_seq and at most one fires per clock.
module dsc_flags #(
    parameter int FULL_SCALE = 20000,
    parameter int UR_LIMIT   = 1800,
    parameter int CW         = 16,
    parameter int RW         = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_positive,
    input  logic [CW-1:0] cnt,
    input  logic          ev_int_start,
    input  logic          ev_deint_start,
    input  logic          ev_end_zc,
    input  logic          ev_end_or,
    output logic          busy,
    output logic          over_range,
    output logic          under_range,
    output logic          polarity,
    output logic [RW-1:0] result
);
    localparam logic [CW-1:0] UR_MAX  = CW'(UR_LIMIT);
    localparam logic [RW-1:0] OR_CODE = RW'(FULL_SCALE + 1);

    // busy: set when integrate starts, clear when the measurement ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy <= 1'b0;
        else if (ev_int_start)           busy <= 1'b1;
        else if (ev_end_zc || ev_end_or) busy <= 1'b0;
    end

    // over_range: set at an over-ranged end, clear at the next deintegrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)              over_range <= 1'b0;
        else if (ev_end_or)      over_range <= 1'b1;
        else if (ev_deint_start) over_range <= 1'b0;
    end

    // under_range: set on a small result at the end, clear at the next integrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)            under_range <= 1'b0;
        else if (ev_end_zc)    under_range <= (cnt <= UR_MAX);
        else if (ev_int_start) under_range <= 1'b0;
    end

    // polarity: capture the input sign as deintegrate begins.
    always_ff @(posedge clk) begin
        if (!rst_n)              polarity <= 1'b0;
        else if (ev_deint_start) polarity <= in_positive;
    end

    // result: latch the deintegrate count, or the over-range code, at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)         result <= '0;
        else if (ev_end_zc) result <= RW'(cnt);
        else if (ev_end_or) result <= OR_CODE;
    end

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_range && under_range)); // R6
    AST_OR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(over_range) |-> $fell(busy)); // R4
    AST_UR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !under_range); // R6
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_deint_start |=> $stable(polarity)); // R7
    AST_OR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (over_range && !ev_deint_start) |=> over_range); // R5
endmodule

// File: rtl/dsc_flag_sequencer.sv
// Top: dual-slope converter phase and status flag controller.
// Wires the phase sequencer to the flag bank and derives the counter widths.
// Assumes: the comparator and sign inputs are already synchronous to clk.
module dsc_flag_sequencer #(
    parameter int AZ_LEN     = 10000,
    parameter int INT_LEN    = 10001,
    parameter int FULL_SCALE = 20000,
    parameter int UR_LIMIT   = 1800,
    localparam int MAXC_A    = (AZ_LEN > INT_LEN) ? AZ_LEN : INT_LEN,
    localparam int MAXC      = (MAXC_A > FULL_SCALE + 2) ? MAXC_A : FULL_SCALE + 2,
    localparam int CW        = $clog2(MAXC + 1),
    localparam int RW        = $clog2(FULL_SCALE + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_cross,
    input  logic          in_positive,
    output logic          busy,
    output logic          over_range,
    output logic          under_range,
    output logic          polarity,
    output logic [RW-1:0] result
);
    dsc_pkg::phase_e phase;
    logic [CW-1:0]   cnt;
    logic            ev_int_start;
    logic            ev_deint_start;
    logic            ev_end_zc;
    logic            ev_end_or;

    dsc_phase_seq #(
        .AZ_LEN     (AZ_LEN),
        .INT_LEN    (INT_LEN),
        .FULL_SCALE (FULL_SCALE),
        .CW         (CW)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .zero_cross     (zero_cross),
        .phase          (phase),
        .cnt            (cnt),
        .ev_int_start   (ev_int_start),
        .ev_deint_start (ev_deint_start),
        .ev_end_zc      (ev_end_zc),
        .ev_end_or      (ev_end_or)
    );

    dsc_flags #(
        .FULL_SCALE (FULL_SCALE),
        .UR_LIMIT   (UR_LIMIT),
        .CW         (CW),
        .RW         (RW)
    ) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_positive    (in_positive),
        .cnt            (cnt),
        .ev_int_start   (ev_int_start),
        .ev_deint_start (ev_deint_start),
        .ev_end_zc      (ev_end_zc),
        .ev_end_or      (ev_end_or),
        .busy           (busy),
        .over_range     (over_range),
        .under_range    (under_range),
        .polarity       (polarity),
        .result         (result)
    );

    AST_BUSY_IN_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != dsc_pkg::PH_AZ) |-> busy); // R2
    AST_BUSY_FALL_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (phase == dsc_pkg::PH_AZ)); // R3
endmodule

// File: tb/test_dsc_flag_sequencer.sv
`timescale 1ns/1ps
// Bench: a behavioural model stepped on each clock and compared with the outputs at every falling edge.
module test_dsc_flag_sequencer;
    localparam int AZ = 20, INTL = 21, FS = 40, UR = 4;
    localparam int RW = $clog2(FS + 2);
    localparam int NMEAS = 8;

    logic clk = 1'b0, rst_n = 1'b0, zero_cross = 1'b0, in_positive = 1'b0;
    logic busy, over_range, under_range, polarity;
    logic [RW-1:0] result;

    int n_chk = 0, n_bad = 0;
    int m_ph = 0, m_cnt = 0, m_busy = 0, m_or = 0, m_ur = 0, m_pol = 0, m_res = 0;
    int done = 0;
    int tgt [NMEAS] = '{10, 4, 5, 0, 40, 60, 1, 41};
    bit glitch_prev = 0;

    always #2.5 clk = ~clk;

    dsc_flag_sequencer #(.AZ_LEN(AZ), .INT_LEN(INTL), .FULL_SCALE(FS), .UR_LIMIT(UR)) i_dsc_flag_sequencer (
        .clk(clk), .rst_n(rst_n), .zero_cross(zero_cross), .in_positive(in_positive),
        .busy(busy), .over_range(over_range), .under_range(under_range),
        .polarity(polarity), .result(result));

    // Reference model: the expected state after each edge, taken from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_busy = 0; m_or = 0; m_ur = 0; m_pol = 0; m_res = 0;
        end else if (m_ph == 0) begin
            if (m_cnt == AZ - 1) begin m_ph = 1; m_cnt = 0; m_busy = 1; m_ur = 0; end
            else m_cnt++;
        end else if (m_ph == 1) begin
            if (m_cnt == INTL - 1) begin m_ph = 2; m_cnt = 0; m_or = 0; m_pol = in_positive; end
            else m_cnt++;
        end else begin
            if (zero_cross) begin
                m_res = m_cnt; m_ur = (m_cnt <= UR); m_busy = 0; m_ph = 0; m_cnt = 0; done++;
            end else if (m_cnt == FS) begin
                m_res = FS + 1; m_or = 1; m_busy = 0; m_ph = 0; m_cnt = 0; done++;
            end else m_cnt++;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    initial begin
        int cyc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "over_range", over_range, 0);
        chk("R1", "under_range", under_range, 0);
        chk("R1", "polarity", polarity, 0);
        chk("R1", "result", result, 0);
        rst_n = 1'b1;
        while (done < NMEAS && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            chk(glitch_prev ? "R8" : "R2", "busy", busy, m_busy);
            chk(m_ph != 0 ? "R5" : "R4", "over_range", over_range, m_or);
            chk("R6", "under_range", under_range, m_ur);
            chk("R7", "polarity", polarity, m_pol);
            chk("R3", "result", result, m_res);
            // Comparator stand-in: cross at the target count, plus stray pulses outside deintegrate (R8).
            glitch_prev = (m_ph != 2) && (m_cnt == 5 || m_cnt == 13);
            zero_cross  = (m_ph == 2 && done < NMEAS && m_cnt == tgt[done]) || glitch_prev;
            // Sign alternates per measurement; flipped mid-deintegrate, which must not reach polarity (R7).
            in_positive = (done % 2 == 0) ^ (m_ph == 2 && m_cnt >= 2);
        end
        if (cyc >= 20000) begin
            n_bad++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", done, NMEAS);
        end
        chk("R9", "measurements completed", done, NMEAS);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule